// File: doc/BRIEF.md
# Switchable-Bank Program ROM Mapper

This block sits on the cartridge side of an 8-bit CPU system with a 16-bit address bus. It serves CPU reads in the upper 32 KB of the address space from a program ROM made of whole 16 KB banks. The lower half of that window, 0x8000 to 0xBFFF, shows whichever bank the bank-select register names. The upper half, 0xC000 to 0xFFFF, is pinned to the final bank. Placing the reset and interrupt vectors in that fixed half keeps them visible whatever bank is selected.

ROM contents can never be changed. A CPU write anywhere in the window loads the bank-select register instead. A separate graphics-bus port gives byte read and write access to a pattern RAM. The ROM image is computed from the ROM address by a fixed function in the package. This lets a large ROM exist without a stored table.

Top module: `bank_rom_mapper`

## Requirements
- R1: When `cpu_re` is high with `cpu_addr` in 0x8000..0xBFFF, `cpu_rdata` one clock later equals the ROM byte at ROM address bank*16384 + `cpu_addr[13:0]`. The ROM byte at ROM address a is ((a mod 256) XOR ((a div 256) mod 64)) + 53*(a div 16384), taken mod 256. `cpu_rdata` changes only on cycles where `cpu_re` was high.
- R2: A read in 0xC000..0xFFFF returns the ROM byte at (BANKS-1)*16384 + `cpu_addr[13:0]`, whatever the bank-select value.
- R3: A write (`cpu_we` high) with `cpu_addr` in 0x8000..0xFFFF loads the bank register. It leaves every ROM byte unchanged.
- R4: After reset the bank register is 0, and `cpu_rdata` and `gfx_rdata` are 0.
- R5: A bank write applies to reads issued from the next cycle on. A read issued in the same cycle as the write still uses the previous bank.
- R6: The value loaded is `cpu_wdata` mod BANKS (BANKS a power of two, default 8), so an out-of-range value wraps.
- R7: A read below 0x8000 returns 0 one cycle later. `rom_cs` is high exactly when `cpu_re` is high and `cpu_addr[15]` is 1. A write below 0x8000 leaves the bank register unchanged.
- R8: A byte written on the graphics port (`gfx_we`) reads back unchanged at the same address. The read uses `gfx_re` and has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | CPU read data, one cycle after the read |
| rom_cs | output | 1 | ROM chip select for the current read |
| gfx_addr | input | PAT_AW | Graphics-bus address |
| gfx_wdata | input | 8 | Graphics write data |
| gfx_we | input | 1 | Graphics write strobe |
| gfx_re | input | 1 | Graphics read strobe |
| gfx_rdata | output | 8 | Graphics read data, one cycle after the read |

## Verification
The bench runs a few fixed sequences first:
- Directed reads of the first bytes of bank 0 and the last bank separate the switchable half from the fixed half.
- A bank switch followed by re-reads of 0xC000 and 0xC001 shows that the fixed half does not follow the register.
- A read and a write issued together tell R5's old-bank behaviour apart from a write that takes effect at once.
- A select value above the bank count exposes a missing wrap.

Constrained random traffic then mixes window writes, writes below the window and reads at any address against a bench model of the bank register. This separates ignored low writes from ones that leak into the register.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  localparam int unsigned BANK_OFS_W = 14;

  // Computed program ROM image, indexed by full ROM address.
  function automatic logic [7:0] rom_byte_f(input logic [31:0] a);
    logic [7:0] lo;
    logic [7:0] mid;
    logic [7:0] bk;
    lo  = a[7:0];
    mid = {2'b00, a[13:8]};
    bk  = 8'(a >> BANK_OFS_W);
    return (lo ^ mid) + 8'(bk * 8'h35);
  endfunction

  function automatic logic in_window_f(input logic [15:0] a);
    return a[15];
  endfunction

endpackage

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
  parameter int unsigned BANKS = 8,
  localparam int unsigned BW = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    wdata,
  output logic [BW-1:0] bank_q
);
  logic [7:0] wrapped;
  assign wrapped = wdata % 8'(BANKS);

  always_ff @(posedge clk) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= wrapped[BW-1:0];
  end
endmodule

// File: rtl/mapper_prog_rom.sv
module mapper_prog_rom #(
  parameter int unsigned ROM_AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic              hit,
  input  logic [ROM_AW-1:0] rom_addr,
  output logic [7:0]        rdata
);
  import bank_mapper_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= hit ? rom_byte_f(32'(rom_addr)) : 8'h00;
  end
endmodule

// File: rtl/mapper_pattern_ram.sv
module mapper_pattern_ram #(
  parameter int unsigned AW = 11,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/bank_rom_mapper.sv
module bank_rom_mapper #(
  parameter int unsigned BANKS  = 8,
  parameter int unsigned PAT_AW = 11,
  localparam int unsigned BW     = $clog2(BANKS),
  localparam int unsigned ROM_AW = BW + bank_mapper_pkg::BANK_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [7:0]        cpu_rdata,
  output logic              rom_cs,
  input  logic [PAT_AW-1:0] gfx_addr,
  input  logic [7:0]        gfx_wdata,
  input  logic              gfx_we,
  input  logic              gfx_re,
  output logic [7:0]        gfx_rdata
);
  import bank_mapper_pkg::*;

  // Named internal events for the checker.
  logic              rom_hit;
  logic              fixed_half;
  logic              bank_load;
  logic [BW-1:0]     bank_q;
  logic [BW-1:0]     eff_bank;
  logic [ROM_AW-1:0] rom_addr;

  assign rom_hit    = in_window_f(cpu_addr);
  assign fixed_half = cpu_addr[14];
  assign bank_load  = cpu_we & rom_hit;
  assign rom_cs     = cpu_re & rom_hit;
  assign eff_bank   = fixed_half ? BW'(BANKS - 1) : bank_q;
  assign rom_addr   = {eff_bank, cpu_addr[BANK_OFS_W-1:0]};

  mapper_bank_reg #(.BANKS(BANKS)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load),
    .wdata(cpu_wdata), .bank_q(bank_q)
  );

  mapper_prog_rom #(.ROM_AW(ROM_AW)) u_rom (
    .clk(clk), .rst_n(rst_n), .re(cpu_re), .hit(rom_hit),
    .rom_addr(rom_addr), .rdata(cpu_rdata)
  );

  mapper_pattern_ram #(.AW(PAT_AW)) u_pat (
    .clk(clk), .rst_n(rst_n), .we(gfx_we), .re(gfx_re),
    .addr(gfx_addr), .wdata(gfx_wdata), .rdata(gfx_rdata)
  );
endmodule

// File: rtl/bank_rom_mapper_chk.sv
module bank_rom_mapper_chk #(
  parameter int unsigned BANKS = 8,
  localparam int unsigned BW     = $clog2(BANKS),
  localparam int unsigned ROM_AW = BW + 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_re,
  input logic [7:0]        cpu_rdata,
  input logic              rom_cs,
  input logic              bank_load,
  input logic [BW-1:0]     bank_q,
  input logic [ROM_AW-1:0] rom_addr
);
  logic [7:0] wrap_exp;
  assign wrap_exp = cpu_wdata % 8'(BANKS);

  AST_SWITCH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] && !cpu_addr[14]) |-> rom_addr[ROM_AW-1:14] == bank_q); // R1
  AST_FIXED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] && cpu_addr[14]) |-> rom_addr[ROM_AW-1:14] == BW'(BANKS - 1)); // R2
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> bank_q == $past(wrap_exp[BW-1:0])); // R6
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(bank_q)); // R7
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && !cpu_addr[15]) |=> cpu_rdata == 8'h00); // R7
  AST_NO_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> !rom_cs); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_re && $past(rst_n)) |=> $stable(cpu_rdata)); // R1
endmodule

bind bank_rom_mapper bank_rom_mapper_chk #(.BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .rom_cs(rom_cs),
  .bank_load(bank_load), .bank_q(bank_q), .rom_addr(rom_addr)
);

// File: tb/bank_rom_mapper_test.sv
`timescale 1ns/1ps
module bank_rom_mapper_test;
  localparam int NB = 8;
  localparam int PAW = 11;

  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic cpu_we = 0, cpu_re = 0;
  logic [7:0] cpu_rdata;
  logic rom_cs;
  logic [PAW-1:0] gfx_addr = 0;
  logic [7:0] gfx_wdata = 0;
  logic gfx_we = 0, gfx_re = 0;
  logic [7:0] gfx_rdata;

  int checks = 0, fails = 0;
  int model_bank = 0;

  always #2.5 clk = ~clk;

  bank_rom_mapper #(.BANKS(NB), .PAT_AW(PAW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .rom_cs(rom_cs),
    .gfx_addr(gfx_addr), .gfx_wdata(gfx_wdata), .gfx_we(gfx_we),
    .gfx_re(gfx_re), .gfx_rdata(gfx_rdata)
  );

  function automatic int exp_rom(int bank, int ofs);
    int a;
    a = bank * 16384 + ofs;
    return (((a % 256) ^ ((a / 256) % 64)) + 53 * (a / 16384)) % 256;
  endfunction

  function automatic int exp_read(int addr, int bank);
    if (addr < 32768) return 0;
    if (addr >= 49152) return exp_rom(NB - 1, addr % 16384);
    return exp_rom(bank, addr % 16384);
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cpu_op(input bit we, input bit re, input logic [15:0] a,
                        input logic [7:0] d, input string req);
    int expv;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = we; cpu_re = re;
    #1;
    chk({req, " R7 rom_cs"}, int'(rom_cs), int'(re && a[15]));
    expv = exp_read(int'(a), model_bank);
    @(posedge clk); #1;
    if (we && a[15]) model_bank = int'(d) % NB;
    if (re) chk(req, int'(cpu_rdata), expv);
    @(negedge clk);
    cpu_we = 0; cpu_re = 0;
  endtask

  task automatic gfx_op(input bit we, input logic [PAW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    gfx_addr = a; gfx_wdata = d; gfx_we = we; gfx_re = !we;
    @(posedge clk); #1;
    @(negedge clk);
    gfx_we = 0; gfx_re = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] gmem [int];
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R4 cpu_rdata reset", int'(cpu_rdata), 0);
    chk("R4 gfx_rdata reset", int'(gfx_rdata), 0);
    @(negedge clk); rst_n = 1;

    cpu_op(0, 1, 16'h8000, 0, "R4 bank0 first byte");
    cpu_op(0, 1, 16'hC000, 0, "R2 fixed first");
    cpu_op(0, 1, 16'hC001, 0, "R2 fixed second");
    cpu_op(1, 0, 16'h9000, 8'h01, "R3 select 1");
    cpu_op(0, 1, 16'h8000, 0, "R1 bank1 first");
    cpu_op(0, 1, 16'hC000, 0, "R2 unchanged after switch");
    cpu_op(0, 1, 16'hC001, 0, "R2 unchanged after switch b");
    cpu_op(1, 0, 16'hFFFF, 8'h12, "R6 wrap 0x12");
    cpu_op(0, 1, 16'h8000, 0, "R6 wrapped bank read");
    cpu_op(0, 1, 16'h9000, 0, "R3 rom not written");
    cpu_op(1, 0, 16'h4000, 8'h05, "R7 low write");
    cpu_op(0, 1, 16'h8010, 0, "R7 bank unchanged by low write");
    cpu_op(0, 1, 16'h1234, 0, "R7 low read zero");
    // same-cycle read + write: read sees old bank
    cpu_op(1, 1, 16'h8002, 8'h03, "R5 same-cycle old bank");
    cpu_op(0, 1, 16'h8002, 0, "R5 new bank next cycle");
    cpu_op(1, 0, 16'hBFFF, 8'hFF, "R6 top value");
    cpu_op(0, 1, 16'hBFFF, 0, "R6 bank 7 via 0xFF");

    gfx_op(1, 11'h100, 8'h89);
    gfx_op(0, 11'h100, 0);
    chk("R8 gfx readback 0x100", int'(gfx_rdata), 8'h89);

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom_range(0, 9));
      a = 16'($urandom);
      if (k < 3) cpu_op(1, 0, a, 8'($urandom), "R3 random write");
      else       cpu_op(0, 1, a, 0, "R1 random read");
    end

    for (int i = 0; i < 40; i++) begin
      logic [PAW-1:0] a;
      logic [7:0] d;
      a = PAW'($urandom);
      d = 8'($urandom);
      gfx_op(1, a, d);
      gmem[int'(a)] = d;
    end
    foreach (gmem[idx]) begin
      gfx_op(0, PAW'(idx), 0);
      chk("R8 gfx random readback", int'(gfx_rdata), int'(gmem[idx]));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule